// File: doc/BRIEF.md
# Strap-Addressed Indirect Register Bridge

This block is the responding side of a management-bus endpoint that holds a set of internal register devices, each with up to 32 16-bit registers. A 4-bit strap input fixes the endpoint's bus address: the strap occupies address bits 4:1 and bit 0 is always zero, so only even addresses can be chosen. The bus side is a plain register access port with a device address, a register offset, read and write enables and a registered response. It does not model pin-level serial framing.

With the strap at zero the endpoint assumes it is alone on the bus. Every bus address then selects the internal device of the same number, and every offset selects that device's register. With a non-zero strap the endpoint shares the bus. It answers only at its own address, and there only through a command register and a data register. Software loads the data register, then writes a command word with its busy bit set. The block holds busy for a fixed latency and then copies between the data register and the internal register the command names. Software polls busy before it reads a result.

Top module: `mgmt_reg_bridge`

## Requirements
- R1: The own address is {strapAddr, 1'b0}. With a non-zero strap, an access is accepted only when busAddr equals the own address and regOff is 0 (command register) or 1 (data register).
- R2: With strapAddr zero, an access to (busAddr, regOff) with busAddr < DEV_COUNT and regOff < REG_COUNT reads or writes register regOff of internal device busAddr directly, all 16 bits included. No indirect operation can start in this mode.
- R3: rspValid is 1 in the cycle after a cycle with rdEn or wrEn high when that access is accepted, and 0 otherwise. A read loads rdData at the same edge.
- R4: An access that is not accepted gives rspValid 0. A read returns 16'hFFFF on rdData. A write changes no register.
- R5: Command word layout: bit 15 busy, bit 12 clause-22 mode flag, bits 11:10 opcode (01 write, 10 read), bits 9:5 target device, bits 4:0 target register. A read of the command register returns bits 14:0 of the last accepted command, with bit 15 equal to the current busy state.
- R6: A command write with bit 15 set while idle is accepted and keeps busy at 1 for exactly BUSY_CYCLES cycles. A command write with bit 15 clear changes nothing.
- R7: An indirect write (bit 12 set, opcode 01) copies the data register into the target register when busy clears. A target outside the device array is left untouched.
- R8: An indirect read (bit 12 set, opcode 10) loads the data register with the target register's value when busy clears. For a target outside the device array it loads 16'hFFFF.
- R9: A command with bit 12 clear, or with opcode 00 or 11, is a no-op. Busy still clears after BUSY_CYCLES cycles, and neither the data register nor any internal register changes.
- R10: A command write that arrives while busy is 1 is ignored. The latched command and its operation are unchanged.
- R11: After reset, rdData, rspValid, busy, the command and data registers and all internal registers are zero.
- R12: When rdEn and wrEn are both high, the access is a write and rdData is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAddr | input | 4 | Address strap, bits 4:1 of the own address |
| busAddr | input | 5 | Bus device address of the access |
| regOff | input | 5 | Register offset of the access |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, loaded one cycle after a read |
| rspValid | output | 1 | Access accepted, one cycle after the request |

## Verification
The bench builds the block with DEV_COUNT = 4, REG_COUNT = 4 and BUSY_CYCLES = 3. With these values the whole 32-by-32 direct address space can be swept in single-chip mode, and most of it then falls outside the array, so the miss path gets as much use as the hit path. In multi-chip mode every target from 0 to 5 in device and register is driven through indirect reads and writes, which covers both in-range and out-of-range targets. A three-cycle busy window is long enough to land a second command inside it and to count the polled busy reads exactly.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int WORD_W   = 16;
  localparam int BUSY_BIT = 15;
  localparam int MODE_BIT = 12;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // source of the word loaded into rdData on a read
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_CMD   = 2'd1,
    SRC_DATA  = 2'd2,
    SRC_NONE  = 2'd3
  } rdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   busy;
    logic   dirWr;
    logic   dataWr;
    logic   cmdLoad;
    logic   xferWr;
    logic   xferRd;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } ctrlStrb_t;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int DEV_COUNT   = 32,
  parameter int REG_COUNT   = 32,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] strapAddr,
  input  logic [4:0] busAddr,
  input  logic [4:0] regOff,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       startBit,
  input  logic [2:0] cmdModeOp,
  output ctrlStrb_t  strb,
  output logic       rspValid
);

  localparam int CNT_W = $clog2(BUSY_CYCLES);

  logic             busy;
  logic [CNT_W-1:0] busyCnt;
  logic             singleMode;
  logic             directOk;
  logic             multiHit;
  logic             hit;
  logic             done;

  assign singleMode = (strapAddr == 4'd0);
  assign directOk   = (int'(busAddr) < DEV_COUNT) && (int'(regOff) < REG_COUNT);
  assign multiHit   = (busAddr == {strapAddr, 1'b0}) && (regOff[4:1] == 4'd0);
  assign hit        = singleMode ? directOk : multiHit;
  assign done       = busy && (busyCnt == '0);

  always_comb begin
    strb.busy    = busy;
    strb.dirWr   = singleMode && hit && wrEn;
    strb.dataWr  = !singleMode && hit && wrEn && regOff[0];
    strb.cmdLoad = !singleMode && hit && wrEn && !regOff[0] && startBit && !busy;
    strb.xferWr  = done && cmdModeOp[2] && (cmdModeOp[1:0] == OP_WRITE);
    strb.xferRd  = done && cmdModeOp[2] && (cmdModeOp[1:0] == OP_READ);
    strb.rdLoad  = rdEn && !wrEn;
    if (!hit)            strb.rdSrc = SRC_NONE;
    else if (singleMode) strb.rdSrc = SRC_ARRAY;
    else if (regOff[0])  strb.rdSrc = SRC_DATA;
    else                 strb.rdSrc = SRC_CMD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      busyCnt  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= (rdEn || wrEn) && hit;
      if (strb.cmdLoad) begin
        busy    <= 1'b1;
        busyCnt <= CNT_W'(BUSY_CYCLES - 1);
      end else if (done) begin
        busy    <= 1'b0;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import bridge_pkg::*;
#(
  parameter int DEV_COUNT = 32,
  parameter int REG_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [4:0]        busAddr,
  input  logic [4:0]        regOff,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [14:0]       cmdWord
);

  localparam int DEV_AW = $clog2(DEV_COUNT);
  localparam int REG_AW = $clog2(REG_COUNT);

  logic [WORD_W-1:0] dataReg;
  logic [4:0]        tgtDev;
  logic [4:0]        tgtReg;
  logic              tgtOk;
  logic [DEV_COUNT-1:0][WORD_W-1:0] dirRow;
  logic [DEV_COUNT-1:0][WORD_W-1:0] tgtRow;
  logic [WORD_W-1:0] arrRead;
  logic [WORD_W-1:0] tgtVal;

  assign tgtDev = cmdWord[9:5];
  assign tgtReg = cmdWord[4:0];
  assign tgtOk  = (int'(tgtDev) < DEV_COUNT) && (int'(tgtReg) < REG_COUNT);

  // one register row per internal device
  for (genvar g = 0; g < DEV_COUNT; g++) begin : g_dev
    logic [WORD_W-1:0] row [REG_COUNT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < REG_COUNT; r++) row[r] <= '0;
      end else if (strb.dirWr && (busAddr == 5'(g))) begin
        row[regOff[REG_AW-1:0]] <= wrData;
      end else if (strb.xferWr && tgtOk && (tgtDev == 5'(g))) begin
        row[tgtReg[REG_AW-1:0]] <= dataReg;
      end
    end

    assign dirRow[g] = row[regOff[REG_AW-1:0]];
    assign tgtRow[g] = row[tgtReg[REG_AW-1:0]];
  end

  assign arrRead = dirRow[busAddr[DEV_AW-1:0]];
  assign tgtVal  = tgtOk ? tgtRow[tgtDev[DEV_AW-1:0]] : {WORD_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      cmdWord <= '0;
      rdData  <= '0;
    end else begin
      if (strb.xferRd)      dataReg <= tgtVal;
      else if (strb.dataWr) dataReg <= wrData;
      if (strb.cmdLoad)     cmdWord <= wrData[14:0];
      if (strb.rdLoad) begin
        unique case (strb.rdSrc)
          SRC_ARRAY: rdData <= arrRead;
          SRC_CMD:   rdData <= {strb.busy, cmdWord};
          SRC_DATA:  rdData <= dataReg;
          default:   rdData <= {WORD_W{1'b1}};
        endcase
      end
    end
  end

endmodule

// File: rtl/mgmt_reg_bridge.sv
module mgmt_reg_bridge
  import bridge_pkg::*;
#(
  parameter int DEV_COUNT   = 32,
  parameter int REG_COUNT   = 32,
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  strapAddr,
  input  logic [4:0]  busAddr,
  input  logic [4:0]  regOff,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        rspValid
);

  ctrlStrb_t   strb;
  logic [14:0] cmdWord;

  bridge_ctrl #(
    .DEV_COUNT  (DEV_COUNT),
    .REG_COUNT  (REG_COUNT),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapAddr(strapAddr),
    .busAddr  (busAddr),
    .regOff   (regOff),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .startBit (wrData[BUSY_BIT]),
    .cmdModeOp(cmdWord[MODE_BIT:10]),
    .strb     (strb),
    .rspValid (rspValid)
  );

  bridge_dp #(
    .DEV_COUNT(DEV_COUNT),
    .REG_COUNT(REG_COUNT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .busAddr(busAddr),
    .regOff (regOff),
    .wrData (wrData),
    .rdData (rdData),
    .cmdWord(cmdWord)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int DEV_COUNT   = 32,
  parameter int REG_COUNT   = 32,
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  strapAddr,
  input logic [4:0]  busAddr,
  input logic [4:0]  regOff,
  input logic        wrEn,
  input logic        rdEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        rspValid,
  input logic        busy,
  input logic        xferWr,
  input logic        xferRd
);

  logic        expHit;
  logic        cmdHit;
  logic [31:0] busyRun;

  assign expHit = (strapAddr == 4'd0)
                ? ((int'(busAddr) < DEV_COUNT) && (int'(regOff) < REG_COUNT))
                : ((busAddr == {strapAddr, 1'b0}) && (regOff < 5'd2));
  assign cmdHit = (strapAddr != 4'd0) && (busAddr == {strapAddr, 1'b0}) && (regOff == 5'd0);

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= '0;
  end

  p_ack_on_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && expHit) |=> rspValid);

  p_no_ack_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn || wrEn) |=> !rspValid);

  p_miss_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && !expHit) |=> !rspValid);

  p_miss_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !expHit) |=> (rdData == 16'hFFFF));

  p_busy_span_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busyRun != 0) |-> (busyRun == BUSY_CYCLES));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && cmdHit && wrData[15]));

  p_xfer_ends_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferWr || xferRd) |-> busy ##1 !busy);

  p_xfer_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(xferWr && xferRd));

  p_single_no_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strapAddr == 4'd0 && $past(strapAddr) == 4'd0) |-> !$rose(busy));

endmodule

bind mgmt_reg_bridge bridge_chk #(
  .DEV_COUNT  (DEV_COUNT),
  .REG_COUNT  (REG_COUNT),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strapAddr(strapAddr),
  .busAddr  (busAddr),
  .regOff   (regOff),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .rspValid (rspValid),
  .busy     (strb.busy),
  .xferWr   (strb.xferWr),
  .xferRd   (strb.xferRd)
);

// File: tb/sim_mgmt_reg_bridge.sv
`timescale 1ns/1ps
module sim_mgmt_reg_bridge;

  localparam int NDEV  = 4;
  localparam int NREG  = 4;
  localparam int BUSYC = 3;
  localparam logic [3:0] STRAP = 4'b0101;
  localparam logic [4:0] OWN   = 5'd10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  strapAddr = 4'd0;
  logic [4:0]  busAddr = '0;
  logic [4:0]  regOff = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rspValid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] mArr [NDEV][NREG];
  logic        gotAck;
  logic [15:0] gotData;

  always #2 clk = ~clk;

  mgmt_reg_bridge #(.DEV_COUNT(NDEV), .REG_COUNT(NREG), .BUSY_CYCLES(BUSYC)) u0 (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .busAddr(busAddr), .regOff(regOff),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .rspValid(rspValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic acc(input bit rd, input bit wr, input logic [4:0] a, input logic [4:0] o,
                     input logic [15:0] d);
    rdEn = rd; wrEn = wr; busAddr = a; regOff = o; wrData = d;
    @(negedge clk);
    gotAck = rspValid; gotData = rdData;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  function automatic logic [15:0] tgtExp(input int dv, input int rg);
    return (dv < NDEV && rg < NREG) ? mArr[dv][rg] : 16'hFFFF;
  endfunction

  // poll the command register until busy is clear; returns busy read count
  task automatic poll(output int n, output logic [15:0] last);
    n = 0;
    acc(1, 0, OWN, 5'd0, '0);
    while (gotData[15] && n < 50) begin
      n++;
      acc(1, 0, OWN, 5'd0, '0);
    end
    last = gotData;
  endtask

  task automatic indirect(input logic [15:0] cmd, input string tag);
    int n;
    logic [15:0] last;
    acc(0, 1, OWN, 5'd0, cmd);
    poll(n, last);
    chk(n == BUSYC, {tag, " busy span R6"}, 16'(n), 16'(BUSYC));
    chk(last == {1'b0, cmd[14:0]}, {tag, " cmd readback R5"}, last, {1'b0, cmd[14:0]});
  endtask

  task automatic indRead(input int dv, input int rg, input string tag);
    logic [15:0] cmd;
    cmd = 16'h9800 | 16'(dv << 5) | 16'(rg);
    indirect(cmd, tag);
    acc(1, 0, OWN, 5'd1, '0);
    chk(gotData == tgtExp(dv, rg), {tag, " data"}, gotData, tgtExp(dv, rg));
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] last, v, prevCmd;
    for (int d = 0; d < NDEV; d++) for (int r = 0; r < NREG; r++) mArr[d][r] = '0;
    repeat (4) @(negedge clk);
    chk(rspValid == 1'b0, "R11 rspValid after reset", 16'(rspValid), 16'h0);
    chk(rdData == 16'h0, "R11 rdData after reset", rdData, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // single-chip mode
    acc(1, 0, 5'd3, 5'd3, '0);
    chk(gotAck && gotData == 16'h0, "R11 array reset", gotData, 16'h0);
    for (int a = 0; a < 32; a++) begin
      for (int r = 0; r < 32; r++) begin
        v = 16'(a * 1000 + r * 7 + 3) | (r[0] ? 16'h8000 : 16'h0);
        acc(0, 1, 5'(a), 5'(r), v);
        chk(gotAck == (a < NDEV && r < NREG), "R3 write ack", 16'(gotAck), 16'(a < NDEV && r < NREG));
        if (a < NDEV && r < NREG) mArr[a][r] = v;
      end
    end
    for (int a = 0; a < 32; a++) begin
      for (int r = 0; r < 32; r++) begin
        bit inR;
        inR = (a < NDEV && r < NREG);
        acc(1, 0, 5'(a), 5'(r), '0);
        chk(gotAck == inR, inR ? "R3 read ack" : "R4 miss ack", 16'(gotAck), 16'(inR));
        chk(gotData == tgtExp(a, r), inR ? "R2 direct read" : "R4 miss data", gotData, tgtExp(a, r));
      end
    end
    // simultaneous read and write acts as a write
    acc(1, 0, 5'd0, 5'd1, '0);
    last = gotData;
    acc(1, 1, 5'd1, 5'd2, 16'hBEEF);
    chk(gotAck && gotData == last, "R12 rdData held", gotData, last);
    mArr[1][2] = 16'hBEEF;
    acc(1, 0, 5'd1, 5'd2, '0);
    chk(gotData == 16'hBEEF, "R12 write took", gotData, 16'hBEEF);
    // command-like word in single-chip mode is a plain register write
    acc(0, 1, 5'd0, 5'd0, 16'h9823);
    mArr[0][0] = 16'h9823;
    acc(1, 0, 5'd0, 5'd0, '0);
    chk(gotData == 16'h9823, "R2 direct full word", gotData, 16'h9823);

    // multi-chip mode
    strapAddr = STRAP;
    for (int a = 0; a < 32; a++) begin
      for (int o = 0; o < 4; o++) begin
        bit h;
        h = (5'(a) == OWN) && (o < 2);
        acc(1, 0, 5'(a), 5'(o), '0);
        chk(gotAck == h, "R1 multi decode", 16'(gotAck), 16'(h));
        chk(gotData == (h ? 16'h0 : 16'hFFFF), h ? "R11 pair reset" : "R4 multi miss", gotData,
            h ? 16'h0 : 16'hFFFF);
      end
    end
    acc(0, 1, 5'd12, 5'd1, 16'h1234);
    acc(0, 1, OWN, 5'd2, 16'h4321);
    acc(0, 1, 5'd0, 5'd0, 16'h9400);
    acc(1, 0, OWN, 5'd1, '0);
    chk(gotData == 16'h0, "R4 miss writes ignored", gotData, 16'h0);
    acc(1, 0, OWN, 5'd0, '0);
    chk(gotData == 16'h0, "R4 miss no command", gotData, 16'h0);

    for (int d = 0; d < 6; d++) for (int r = 0; r < 6; r++) indRead(d, r, "R8 indirect read");

    for (int d = 0; d < 6; d++) begin
      for (int r = 0; r < 6; r++) begin
        v = 16'hA000 | 16'(d * 256 + r);
        acc(0, 1, OWN, 5'd1, v);
        indirect(16'h9400 | 16'(d << 5) | 16'(r), "R7 indirect write");
        if (d < NDEV && r < NREG) mArr[d][r] = v;
        indRead(d, r, "R7 write readback");
      end
    end

    // no-op commands
    foreach (mArr[0][i]) begin end
    begin
      logic [15:0] noops [4];
      noops[0] = 16'h9000 | 16'(1 << 5) | 16'd1;
      noops[1] = 16'h9C00 | 16'(1 << 5) | 16'd1;
      noops[2] = 16'h8400 | 16'(1 << 5) | 16'd1;
      noops[3] = 16'h8800 | 16'(1 << 5) | 16'd1;
      for (int k = 0; k < 4; k++) begin
        acc(0, 1, OWN, 5'd1, 16'h5A5A);
        indirect(noops[k], "R9 no-op");
        acc(1, 0, OWN, 5'd1, '0);
        chk(gotData == 16'h5A5A, "R9 data unchanged", gotData, 16'h5A5A);
        indRead(1, 1, "R9 target unchanged");
      end
    end

    // command written while busy
    acc(0, 1, OWN, 5'd1, 16'h7777);
    acc(0, 1, OWN, 5'd0, 16'h9400 | 16'(2 << 5) | 16'd3);
    acc(0, 1, OWN, 5'd0, 16'h9400);
    poll(n, last);
    chk(n == BUSYC - 1, "R10 busy span kept", 16'(n), 16'(BUSYC - 1));
    chk(last == (16'h1400 | 16'(2 << 5) | 16'd3), "R10 cmd kept", last, 16'h1400 | 16'(2 << 5) | 16'd3);
    mArr[2][3] = 16'h7777;
    indRead(2, 3, "R10 first op done");
    indRead(0, 0, "R10 second op dropped");

    // command write with busy bit clear
    acc(1, 0, OWN, 5'd0, '0);
    prevCmd = gotData;
    acc(0, 1, OWN, 5'd0, 16'h1800 | 16'(3 << 5) | 16'd2);
    acc(1, 0, OWN, 5'd0, '0);
    chk(gotData == prevCmd, "R6 clear start ignored", gotData, prevCmd);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule